// File: doc/BRIEF.md
# Two-Channel Instruction Breakpoint Controller

This debug unit watches the stream of instructions that the processor has committed to execute and compares each one's address against two programmable channels, A and B. A channel that is enabled and whose address matches raises a sticky match flag and, unless the CPU is blocking exceptions, a one-cycle break request. Each channel chooses whether its break is taken before the matched instruction runs or after it completes. Only instructions confirmed to execute are presented, so prefetched instructions that were discarded never cause a break.

In sequential mode the two channels form a chain. A match on A only arms the unit (FSM state `SQ_WAIT_A` → `SQ_WAIT_B`, transition "arm"). A later match on B then breaks at B's instruction, sets only B's flag and returns to `SQ_WAIT_A` (transition "fire"). Clearing the sequential bit forces `SQ_WAIT_A` (transition "discard"). Outside sequential mode the FSM stays in `SQ_WAIT_A`. For delay slots, a pre-execution break on a slot instruction is reported as a restart at the owning branch. A pre-execution condition on the slot of a return-from-exception is never honoured.

Software programs the unit through a small synchronous register port with four words. Offset 0 holds the channel A address and offset 1 the channel B address. Offset 2 is control: bit0 A enable, bit1 A post-execution, bit2 B enable, bit3 B post-execution, bit4 sequential mode. Offset 3 is status: bit0 A flag, bit1 B flag.

Top module: `ibrk_unit`

## Requirements
- R1: When an enabled channel matches an executed instruction and cpu_bl is 0, the channel's flag is 1 and brk_req is high for exactly one cycle, both visible after the clock edge that sampled the instruction.
- R2: When cpu_bl is 1 during a match, the flag is still set but brk_req stays 0.
- R3: Flags are sticky: hardware never clears them. Writing status (offset 3) clears each flag whose write bit is 0; a write bit of 1 leaves that flag unchanged.
- R4: Address comparison ignores bit 0 of the executed address. A channel whose address register has bit 0 set never matches.
- R5: brk_post is 1 with a break taken after execution (control post bit 1) and 0 for a pre-execution break. If pre and post channels hit the same instruction outside sequential mode, the pre-execution break wins.
- R6: Cycles with exec_valid at 0 never set a flag or raise a break.
- R7: A pre-execution break on an instruction with exec_in_slot set drives brk_to_branch to 1 together with brk_req. brk_to_branch is 0 otherwise.
- R8: With exec_rte_slot set, a channel configured for pre-execution does not match: no flag, no break. A post-execution channel still matches.
- R9: In sequential mode a channel B match breaks only if channel A matched on an earlier instruction since the last arm/fire/discard. The break uses B's pre/post selection and then re-waits for A.
- R10: In sequential mode flag A is never set; only flag B is set, on the breaking B match.
- R11: Writing 0 to the sequential bit discards a pending A match, so a subsequent B match in re-enabled sequential mode does not break.
- R12: In sequential mode, an instruction that matches both A and B while waiting for A only arms; it does not break.
- R13: Registers read back the values written: both addresses in full, control bits [4:0], status bits [1:0]. All read 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| exec_valid | input | 1 | An instruction is confirmed to execute this cycle |
| exec_addr | input | AW | Address of that instruction |
| exec_in_slot | input | 1 | Instruction is in a delayed-branch slot |
| exec_rte_slot | input | 1 | Instruction is in the slot of a return-from-exception |
| cpu_bl | input | 1 | CPU exception block bit |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word offset |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data (combinational) |
| brk_req | output | 1 | Break exception request pulse |
| brk_post | output | 1 | Break is after execution |
| brk_to_branch | output | 1 | Restart at the delayed branch owning the slot |
| flag_a | output | 1 | Channel A sticky match flag |
| flag_b | output | 1 | Channel B sticky match flag |

## Verification
A wrong sequencer state shows up at the ports on the next channel B match. A missed arm produces no break where one was due. A stale arm produces a break after the sequential bit was cleared or after a same-instruction A/B hit. Both errors are visible one cycle after the instruction. Comparator or gating faults surface in the very next cycle as a wrong brk_req, brk_post or brk_to_branch value, or as a flag that rises or falls when it should not. A flag fault then persists until software clears it, so later reads expose it as well.

// File: rtl/ibrk_pkg.sv
package ibrk_pkg;
    localparam int NCH = 2;

    localparam logic [1:0] OFS_ADDR_A = 2'd0;
    localparam logic [1:0] OFS_ADDR_B = 2'd1;
    localparam logic [1:0] OFS_CTRL   = 2'd2;
    localparam logic [1:0] OFS_STAT   = 2'd3;

    localparam int CB_EN_A   = 0;
    localparam int CB_POST_A = 1;
    localparam int CB_EN_B   = 2;
    localparam int CB_POST_B = 3;
    localparam int CB_SEQ    = 4;

    typedef enum logic [0:0] {
        SQ_WAIT_A = 1'b0,
        SQ_WAIT_B = 1'b1
    } seq_state_e;

    typedef struct packed {
        logic en;
        logic post;
    } chan_cfg_t;
endpackage

// File: rtl/ibrk_chan_cmp.sv
module ibrk_chan_cmp
    import ibrk_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          exec_valid,
    input  logic [AW-1:0] exec_addr,
    input  logic          exec_rte_slot,
    input  logic [AW-1:0] ref_addr,
    input  chan_cfg_t     cfg,
    output logic          hit
);
    localparam logic [AW-1:0] CMP_MASK = {{(AW-1){1'b1}}, 1'b0};

    logic addr_eq;
    logic ref_ok;
    logic rte_block;

    always_comb begin
        addr_eq   = ((exec_addr ^ ref_addr) & CMP_MASK) == '0;
        ref_ok    = ~ref_addr[0];
        rte_block = exec_rte_slot & ~cfg.post;
        hit       = exec_valid & cfg.en & ref_ok & addr_eq & ~rte_block;
    end
endmodule

// File: rtl/ibrk_regs.sv
module ibrk_regs
    import ibrk_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    reg_we,
    input  logic [1:0]              reg_addr,
    input  logic [DW-1:0]           reg_wdata,
    output logic [DW-1:0]           reg_rdata,
    input  logic [NCH-1:0]          set_flag,
    output logic [NCH-1:0][AW-1:0]  addr_q,
    output chan_cfg_t [NCH-1:0]     cfg_q,
    output logic                    seq_mode,
    output logic [NCH-1:0]          flag_q
);
    logic wr_stat;

    always_comb wr_stat = reg_we && (reg_addr == OFS_STAT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q   <= '0;
            cfg_q    <= '0;
            seq_mode <= 1'b0;
        end else if (reg_we) begin
            unique case (reg_addr)
                OFS_ADDR_A: addr_q[0] <= reg_wdata[AW-1:0];
                OFS_ADDR_B: addr_q[1] <= reg_wdata[AW-1:0];
                OFS_CTRL: begin
                    cfg_q[0].en   <= reg_wdata[CB_EN_A];
                    cfg_q[0].post <= reg_wdata[CB_POST_A];
                    cfg_q[1].en   <= reg_wdata[CB_EN_B];
                    cfg_q[1].post <= reg_wdata[CB_POST_B];
                    seq_mode      <= reg_wdata[CB_SEQ];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= (wr_stat ? (flag_q & reg_wdata[NCH-1:0]) : flag_q) | set_flag;
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            OFS_ADDR_A: reg_rdata[AW-1:0] = addr_q[0];
            OFS_ADDR_B: reg_rdata[AW-1:0] = addr_q[1];
            OFS_CTRL: begin
                reg_rdata[CB_EN_A]   = cfg_q[0].en;
                reg_rdata[CB_POST_A] = cfg_q[0].post;
                reg_rdata[CB_EN_B]   = cfg_q[1].en;
                reg_rdata[CB_POST_B] = cfg_q[1].post;
                reg_rdata[CB_SEQ]    = seq_mode;
            end
            OFS_STAT: reg_rdata[NCH-1:0] = flag_q;
            default: ;
        endcase
    end
endmodule

// File: rtl/ibrk_seq_fsm.sv
module ibrk_seq_fsm
    import ibrk_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                seq_mode,
    input  logic [NCH-1:0]      hit,
    input  chan_cfg_t [NCH-1:0] cfg,
    input  logic                exec_in_slot,
    input  logic                cpu_bl,
    output logic [NCH-1:0]      set_flag,
    output logic                brk_req,
    output logic                brk_post,
    output logic                brk_to_branch
);
    seq_state_e state_q, state_d;
    logic       fire;
    logic       post_sel;
    logic       take;

    always_comb begin
        state_d  = state_q;
        fire     = 1'b0;
        post_sel = 1'b1;
        set_flag = '0;
        if (!seq_mode) begin
            state_d  = SQ_WAIT_A;
            set_flag = hit;
            fire     = |hit;
            post_sel = ~((hit[0] & ~cfg[0].post) | (hit[1] & ~cfg[1].post));
        end else begin
            unique case (state_q)
                SQ_WAIT_A: begin
                    if (hit[0]) state_d = SQ_WAIT_B;
                end
                SQ_WAIT_B: begin
                    if (hit[1]) begin
                        set_flag[1] = 1'b1;
                        fire        = 1'b1;
                        post_sel    = cfg[1].post;
                        state_d     = SQ_WAIT_A;
                    end
                end
            endcase
        end
        take = fire & ~cpu_bl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SQ_WAIT_A;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            brk_req       <= 1'b0;
            brk_post      <= 1'b0;
            brk_to_branch <= 1'b0;
        end else begin
            brk_req       <= take;
            brk_post      <= take & post_sel;
            brk_to_branch <= take & ~post_sel & exec_in_slot;
        end
    end
endmodule

// File: rtl/ibrk_unit.sv
module ibrk_unit
    import ibrk_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          exec_valid,
    input  logic [AW-1:0] exec_addr,
    input  logic          exec_in_slot,
    input  logic          exec_rte_slot,
    input  logic          cpu_bl,
    input  logic          reg_we,
    input  logic [1:0]    reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          brk_req,
    output logic          brk_post,
    output logic          brk_to_branch,
    output logic          flag_a,
    output logic          flag_b
);
    logic [NCH-1:0][AW-1:0] addr_q;
    chan_cfg_t [NCH-1:0]    cfg_q;
    logic                   seq_mode;
    logic [NCH-1:0]         flag_q;
    logic [NCH-1:0]         hit;
    logic [NCH-1:0]         set_flag;

    ibrk_regs #(.AW(AW), .DW(DW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .set_flag  (set_flag),
        .addr_q    (addr_q),
        .cfg_q     (cfg_q),
        .seq_mode  (seq_mode),
        .flag_q    (flag_q)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        ibrk_chan_cmp #(.AW(AW)) u_cmp (
            .exec_valid    (exec_valid),
            .exec_addr     (exec_addr),
            .exec_rte_slot (exec_rte_slot),
            .ref_addr      (addr_q[g]),
            .cfg           (cfg_q[g]),
            .hit           (hit[g])
        );
    end

    ibrk_seq_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .seq_mode      (seq_mode),
        .hit           (hit),
        .cfg           (cfg_q),
        .exec_in_slot  (exec_in_slot),
        .cpu_bl        (cpu_bl),
        .set_flag      (set_flag),
        .brk_req       (brk_req),
        .brk_post      (brk_post),
        .brk_to_branch (brk_to_branch)
    );

    assign flag_a = flag_q[0];
    assign flag_b = flag_q[1];
endmodule

// File: rtl/ibrk_unit_chk.sv
module ibrk_unit_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       exec_valid,
    input logic       exec_rte_slot,
    input logic       cpu_bl,
    input logic       reg_we,
    input logic [1:0] reg_addr,
    input logic       brk_req,
    input logic       brk_post,
    input logic       brk_to_branch,
    input logic       flag_a,
    input logic       flag_b,
    input logic       seq_mode,
    input logic       post_a,
    input logic       post_b,
    input logic       odd_a
);
    logic stat_wr;
    assign stat_wr = reg_we && (reg_addr == 2'd3);

    assert_block_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_valid && cpu_bl) |=> !brk_req);

    assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !exec_valid |=> !brk_req);

    assert_sticky_a_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_a && !stat_wr) |=> flag_a);

    assert_sticky_b_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_b && !stat_wr) |=> flag_b);

    assert_seq_no_flag_a_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_a) |-> !$past(seq_mode));

    assert_odd_addr_dead_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_a) |-> !$past(odd_a));

    assert_branch_is_pre_R7: assert property (@(posedge clk) disable iff (!rst_n)
        brk_to_branch |-> (brk_req && !brk_post));

    assert_rte_slot_pre_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_valid && exec_rte_slot && !post_a && !post_b) |=> !brk_req);

    assert_post_with_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
        brk_post |-> brk_req);
endmodule

bind ibrk_unit ibrk_unit_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .exec_valid    (exec_valid),
    .exec_rte_slot (exec_rte_slot),
    .cpu_bl        (cpu_bl),
    .reg_we        (reg_we),
    .reg_addr      (reg_addr),
    .brk_req       (brk_req),
    .brk_post      (brk_post),
    .brk_to_branch (brk_to_branch),
    .flag_a        (flag_a),
    .flag_b        (flag_b),
    .seq_mode      (seq_mode),
    .post_a        (cfg_q[0].post),
    .post_b        (cfg_q[1].post),
    .odd_a         (addr_q[0][0])
);

// File: tb/ibrk_unit_tb.sv
module ibrk_unit_tb;
    localparam int AW = 32;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          exec_valid = 1'b0;
    logic [AW-1:0] exec_addr = '0;
    logic          exec_in_slot = 1'b0;
    logic          exec_rte_slot = 1'b0;
    logic          cpu_bl = 1'b0;
    logic          reg_we = 1'b0;
    logic [1:0]    reg_addr = '0;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic          brk_req, brk_post, brk_to_branch, flag_a, flag_b;

    int n_chk = 0;
    int n_fail = 0;

    logic [AW-1:0] m_addr [2];
    logic          m_en [2];
    logic          m_post [2];
    logic          m_seq, m_fa, m_fb, m_armed;

    always #2 clk = ~clk;

    ibrk_unit #(.AW(AW), .DW(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .exec_valid(exec_valid), .exec_addr(exec_addr),
        .exec_in_slot(exec_in_slot), .exec_rte_slot(exec_rte_slot), .cpu_bl(cpu_bl),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .brk_req(brk_req), .brk_post(brk_post), .brk_to_branch(brk_to_branch),
        .flag_a(flag_a), .flag_b(flag_b)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [1:0] a, input logic [31:0] exp);
        reg_addr = a;
        #1;
        chk(tag, reg_rdata, exp);
    endtask

    task automatic set_ctrl(input logic ea, input logic pa, input logic eb, input logic pb, input logic sq);
        wr(2'd2, {27'd0, sq, pb, eb, pa, ea});
        m_en[0] = ea; m_post[0] = pa; m_en[1] = eb; m_post[1] = pb;
        m_seq = sq;
        if (!sq) m_armed = 1'b0;
    endtask

    task automatic set_addr(input int ch, input logic [31:0] a);
        wr(ch[1:0], a);
        m_addr[ch] = a;
    endtask

    task automatic stat_wr(input logic [1:0] d);
        wr(2'd3, {30'd0, d});
        m_fa = m_fa & d[0];
        m_fb = m_fb & d[1];
    endtask

    task automatic step(input string tag, input logic v, input logic [31:0] a,
                        input logic slot, input logic rte, input logic bl);
        logic mh0, mh1, fire, psel, er, ep, eb;
        mh0 = v && m_en[0] && !m_addr[0][0] && (a[31:1] == m_addr[0][31:1]) && !(!m_post[0] && rte);
        mh1 = v && m_en[1] && !m_addr[1][0] && (a[31:1] == m_addr[1][31:1]) && !(!m_post[1] && rte);
        fire = 1'b0; psel = 1'b1;
        if (!m_seq) begin
            fire = mh0 | mh1;
            m_fa = m_fa | mh0;
            m_fb = m_fb | mh1;
            psel = !((mh0 && !m_post[0]) || (mh1 && !m_post[1]));
        end else if (m_armed) begin
            if (mh1) begin
                m_fb = 1'b1; fire = 1'b1; psel = m_post[1]; m_armed = 1'b0;
            end
        end else if (mh0) begin
            m_armed = 1'b1;
        end
        er = fire && !bl;
        ep = er && psel;
        eb = er && !psel && slot;
        exec_valid = v; exec_addr = a; exec_in_slot = slot; exec_rte_slot = rte; cpu_bl = bl;
        @(negedge clk);
        exec_valid = 1'b0; exec_in_slot = 1'b0; exec_rte_slot = 1'b0; cpu_bl = 1'b0;
        chk({tag, " brk_req"}, {31'd0, brk_req}, {31'd0, er});
        chk({tag, " brk_post"}, {31'd0, brk_post}, {31'd0, ep});
        chk({tag, " brk_to_branch"}, {31'd0, brk_to_branch}, {31'd0, eb});
        chk({tag, " flag_a"}, {31'd0, flag_a}, {31'd0, m_fa});
        chk({tag, " flag_b"}, {31'd0, flag_b}, {31'd0, m_fb});
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        m_addr[0] = '0; m_addr[1] = '0; m_en[0] = 0; m_en[1] = 0;
        m_post[0] = 0; m_post[1] = 0; m_seq = 0; m_fa = 0; m_fb = 0; m_armed = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R13 reset state
        for (int r = 0; r < 4; r++) rd_chk("R13 reset read", r[1:0], 32'd0);
        chk("R1 reset brk_req", {31'd0, brk_req}, 32'd0);

        // R13 readback
        set_addr(0, 32'h0000_1230);
        set_addr(1, 32'h0000_4560);
        set_ctrl(1, 0, 1, 1, 1);
        rd_chk("R13 addr A", 2'd0, 32'h0000_1230);
        rd_chk("R13 addr B", 2'd1, 32'h0000_4560);
        rd_chk("R13 ctrl", 2'd2, 32'h0000_001D);
        set_ctrl(0, 0, 0, 0, 0);

        // R1 R2 R4 R5 R7 R8: per-channel sweep
        for (int ch = 0; ch < 2; ch++) begin
            for (int k = 0; k < 64; k++) begin
                logic en, po, bl, sl, rt, ht;
                logic [31:0] ea;
                {en, po, bl, sl, rt, ht} = k[5:0];
                if (ch == 0) set_ctrl(en, po, 0, 0, 0);
                else         set_ctrl(0, 0, en, po, 0);
                stat_wr(2'b00);
                ea = ht ? (m_addr[ch] | {31'd0, bl}) : (m_addr[ch] + 32'd8);
                step($sformatf("R1 R2 R4 R5 R7 R8 sweep ch%0d k%0d", ch, k), 1'b1, ea, sl, rt, bl);
            end
        end

        // R5 pre wins over post on the same instruction
        set_addr(1, 32'h0000_1230);
        set_ctrl(1, 0, 1, 1, 0);
        stat_wr(2'b00);
        step("R5 pre wins", 1'b1, 32'h0000_1230, 1'b0, 1'b0, 1'b0);
        set_ctrl(1, 1, 1, 1, 0);
        stat_wr(2'b00);
        step("R5 both post", 1'b1, 32'h0000_1230, 1'b0, 1'b0, 1'b0);

        // R3 sticky and write-0-to-clear
        step("R3 idle keep", 1'b0, 32'h0, 1'b0, 1'b0, 1'b0);
        step("R3 idle keep2", 1'b1, 32'h0000_9990, 1'b0, 1'b0, 1'b0);
        stat_wr(2'b11);
        rd_chk("R3 write ones keeps", 2'd3, 32'd3);
        stat_wr(2'b10);
        rd_chk("R3 clear A only", 2'd3, 32'd2);
        stat_wr(2'b00);
        rd_chk("R3 clear all", 2'd3, 32'd0);

        // R6 exec_valid low with matching address
        step("R6 invalid", 1'b0, 32'h0000_1230, 1'b0, 1'b0, 1'b0);

        // R4 odd channel address never matches
        set_addr(0, 32'h0000_1231);
        set_ctrl(1, 1, 0, 0, 0);
        step("R4 odd addr even exec", 1'b1, 32'h0000_1230, 1'b0, 1'b0, 1'b0);
        step("R4 odd addr odd exec", 1'b1, 32'h0000_1231, 1'b0, 1'b0, 1'b0);
        set_addr(0, 32'h0000_1230);
        set_addr(1, 32'h0000_4560);

        // R9 R10 sequential chain
        set_ctrl(1, 0, 1, 1, 1);
        stat_wr(2'b00);
        step("R9 B before A", 1'b1, 32'h0000_4560, 1'b0, 1'b0, 1'b0);
        step("R10 A arms", 1'b1, 32'h0000_1230, 1'b0, 1'b0, 1'b0);
        step("R9 unrelated", 1'b1, 32'h0000_7770, 1'b0, 1'b0, 1'b0);
        step("R9 B fires", 1'b1, 32'h0000_4560, 1'b0, 1'b0, 1'b0);
        step("R9 B again idle", 1'b1, 32'h0000_4560, 1'b0, 1'b0, 1'b0);

        // R9 R7 sequential pre on slot, and blocked
        set_ctrl(1, 0, 1, 0, 1);
        stat_wr(2'b00);
        step("R9 arm2", 1'b1, 32'h0000_1230, 1'b0, 1'b0, 1'b0);
        step("R7 seq B pre slot", 1'b1, 32'h0000_4560, 1'b1, 1'b0, 1'b0);
        step("R9 arm3", 1'b1, 32'h0000_1230, 1'b0, 1'b0, 1'b0);
        step("R2 seq blocked", 1'b1, 32'h0000_4560, 1'b0, 1'b0, 1'b1);
        step("R9 after block", 1'b1, 32'h0000_4560, 1'b0, 1'b0, 1'b0);

        // R11 discard pending
        stat_wr(2'b00);
        step("R11 arm", 1'b1, 32'h0000_1230, 1'b0, 1'b0, 1'b0);
        set_ctrl(1, 0, 1, 0, 0);
        set_ctrl(1, 0, 1, 0, 1);
        step("R11 B after discard", 1'b1, 32'h0000_4560, 1'b0, 1'b0, 1'b0);

        // R12 same instruction A and B
        set_addr(1, 32'h0000_1230);
        set_ctrl(1, 1, 1, 1, 1);
        stat_wr(2'b00);
        step("R12 same instr arms", 1'b1, 32'h0000_1230, 1'b0, 1'b0, 1'b0);
        step("R12 next instr fires", 1'b1, 32'h0000_1230, 1'b0, 1'b0, 1'b0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule